// File: doc/BRIEF.md
# USB Endpoint Handshake Responder

This block sits on the device side of a USB function. It decides which handshake the function returns after the data packet of an OUT or SETUP token. For each token it takes the decoded token kind, the 4-bit endpoint number, the data PID parity and a good-packet flag from an external CRC checker. It also reads per-endpoint vectors that mark each endpoint as control or non-control, halted, and buffer-ready.

The block registers its decision and shows it one clock after the token strobe. The decision is a 2-bit handshake code, a data-accept strobe, and an update of the per-endpoint data-toggle state, which is visible on an output vector. A SETUP to a control endpoint always gets ACK and resynchronises the toggle. A corrupted packet, a SETUP to a non-control endpoint, or an endpoint number outside the configured range gets no handshake at all. Endpoint 0 is treated as a control endpoint whatever the type vector says.

Top module: `usb_ep_handshake`

## Requirements
- R1: While and right after reset, `hs_code` is 00, `data_accept` is 0 and every bit of `ep_toggle` is 0 (next data PID expected is DATA0).
- R2: A token strobed on `tok_valid` in cycle N produces its result in cycle N+1 only. `hs_code` uses 00 = none, 01 = ACK, 10 = NAK, 11 = STALL, and it is 00 in every cycle that does not follow a token strobe. Tokens may arrive on consecutive cycles.
- R3: When `data_ok` is 0, for OUT or SETUP, `hs_code` is 00, `data_accept` stays 0 and `ep_toggle` is unchanged.
- R4: An intact SETUP to a control endpoint gives ACK with `data_accept` high, even when that endpoint is halted and its buffer is not ready.
- R5: An accepted SETUP sets that endpoint's `ep_toggle` bit to 1 (DATA1 expected next), whatever its previous value.
- R6: An intact SETUP to a non-control endpoint gives `hs_code` 00, no `data_accept`, and no toggle change.
- R7: Endpoint 0 behaves as a control endpoint even when `ep_is_ctrl[0]` is 0.
- R8: An intact OUT to a halted endpoint gives STALL, whatever its buffer-ready flag, with no accept and no toggle change.
- R9: An intact OUT to an endpoint that is not halted and not ready gives NAK, with no accept and no toggle change.
- R10: An intact OUT to a ready, non-halted endpoint whose data PID parity (`data_pid_odd`, 1 = DATA1) equals that endpoint's `ep_toggle` bit gives ACK, pulses `data_accept` and inverts that toggle bit.
- R11: An intact OUT to a ready, non-halted endpoint whose data PID parity differs from its toggle bit gives ACK, leaves `data_accept` low and leaves the toggle unchanged.
- R12: A token whose endpoint number is NUM_EP or above gives `hs_code` 00 and no accept, and changes no toggle.
- R13: A token changes at most the toggle bit of the endpoint it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-cycle strobe: a data packet for a token has just finished |
| tok_is_setup | input | 1 | 1 = SETUP token, 0 = OUT token |
| tok_ep | input | 4 | Endpoint number from the token |
| data_pid_odd | input | 1 | Data PID of the packet: 0 = DATA0, 1 = DATA1 |
| data_ok | input | 1 | Packet passed CRC and format checks |
| ep_is_ctrl | input | NUM_EP | Per-endpoint control-type flag (bit 0 is overridden to 1) |
| ep_halt | input | NUM_EP | Per-endpoint halt flag |
| ep_ready | input | NUM_EP | Per-endpoint buffer-ready flag |
| hs_code | output | 2 | Handshake request pulse: 00 none, 01 ACK, 10 NAK, 11 STALL |
| data_accept | output | 1 | Pulse: the packet's data is to be kept |
| ep_toggle | output | NUM_EP | Per-endpoint expected data PID parity |

## Verification
A toggle bit that is wrong inside the block shows at the ports as early as the next OUT to that endpoint. That OUT still gets ACK, but `data_accept` takes the wrong value in the cycle after the token, and the `ep_toggle` bit moves when it should hold, or holds when it should move. Because `ep_toggle` is itself a port, a stray write to an endpoint that was not addressed can be seen in the cycle after any token. A wrong priority between halt, ready and token kind can be seen on `hs_code` one cycle after the strobe.

// File: rtl/usbhs_pkg.sv
package usbhs_pkg;
   localparam int EP_FIELD_W = 4;
   localparam int EP_MAX     = 1 << EP_FIELD_W;

   typedef enum logic [1:0] {
      HS_NONE  = 2'b00,
      HS_ACK   = 2'b01,
      HS_NAK   = 2'b10,
      HS_STALL = 2'b11
   } hs_code_t;

   typedef struct packed {
      hs_code_t code;
      logic     accept;
      logic     tog_set;
      logic     tog_flip;
   } verdict_t;
endpackage

// File: rtl/usbhs_ep_select.sv
module usbhs_ep_select
   import usbhs_pkg::*;
#(
   parameter int NUM_EP = 16
) (
   input  logic [EP_FIELD_W-1:0] ep,
   input  logic [NUM_EP-1:0]     ctrl_vec,
   input  logic [NUM_EP-1:0]     halt_vec,
   input  logic [NUM_EP-1:0]     ready_vec,
   input  logic [NUM_EP-1:0]     tog_vec,
   output logic                  in_range,
   output logic                  is_ctrl,
   output logic                  halted,
   output logic                  ready,
   output logic                  tog
);
   localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
   localparam int PAD   = 1 << IDX_W;

   logic [NUM_EP-1:0] ctrl_eff;
   logic [PAD-1:0]    ctrl_p, halt_p, ready_p, tog_p;
   logic [IDX_W-1:0]  idx;

   generate
      if (NUM_EP > 1) begin : g_ctrl_multi
         assign ctrl_eff = {ctrl_vec[NUM_EP-1:1], 1'b1};
      end else begin : g_ctrl_single
         assign ctrl_eff = 1'b1;
      end

      if (NUM_EP == EP_MAX) begin : g_full_range
         assign in_range = 1'b1;
      end else begin : g_part_range
         assign in_range = (ep < EP_FIELD_W'(NUM_EP));
      end
   endgenerate

   assign idx     = ep[IDX_W-1:0];
   assign ctrl_p  = PAD'(ctrl_eff);
   assign halt_p  = PAD'(halt_vec);
   assign ready_p = PAD'(ready_vec);
   assign tog_p   = PAD'(tog_vec);

   assign is_ctrl = ctrl_p[idx];
   assign halted  = halt_p[idx];
   assign ready   = ready_p[idx];
   assign tog     = tog_p[idx];
endmodule

// File: rtl/usbhs_decide.sv
module usbhs_decide
   import usbhs_pkg::*;
(
   input  logic     is_setup,
   input  logic     data_ok,
   input  logic     in_range,
   input  logic     is_ctrl,
   input  logic     halted,
   input  logic     ready,
   input  logic     pid_odd,
   input  logic     tog,
   output verdict_t verdict
);
   always_comb begin
      verdict = '{code: HS_NONE, accept: 1'b0, tog_set: 1'b0, tog_flip: 1'b0};
      if (in_range && data_ok) begin
         if (is_setup) begin
            if (is_ctrl) begin
               verdict.code    = HS_ACK;
               verdict.accept  = 1'b1;
               verdict.tog_set = 1'b1;
            end
         end else if (halted) begin
            verdict.code = HS_STALL;
         end else if (!ready) begin
            verdict.code = HS_NAK;
         end else begin
            verdict.code     = HS_ACK;
            verdict.accept   = (pid_odd == tog);
            verdict.tog_flip = (pid_odd == tog);
         end
      end
   end
endmodule

// File: rtl/usbhs_toggle_bank.sv
module usbhs_toggle_bank
   import usbhs_pkg::*;
#(
   parameter int NUM_EP = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [EP_FIELD_W-1:0] ep,
   input  logic                  set,
   input  logic                  flip,
   output logic [NUM_EP-1:0]     tog_vec
);
   genvar i;
   generate
      for (i = 0; i < NUM_EP; i++) begin : g_tog
         logic hit;
         assign hit = wr_en && (ep == EP_FIELD_W'(i));
         always_ff @(posedge clk) begin
            if (!rst_n)
               tog_vec[i] <= 1'b0;
            else if (hit && set)
               tog_vec[i] <= 1'b1;
            else if (hit && flip)
               tog_vec[i] <= ~tog_vec[i];
         end
      end
   endgenerate
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
   import usbhs_pkg::*;
#(
   parameter int NUM_EP = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tok_valid,
   input  logic              tok_is_setup,
   input  logic [3:0]        tok_ep,
   input  logic              data_pid_odd,
   input  logic              data_ok,
   input  logic [NUM_EP-1:0] ep_is_ctrl,
   input  logic [NUM_EP-1:0] ep_halt,
   input  logic [NUM_EP-1:0] ep_ready,
   output logic [1:0]        hs_code,
   output logic              data_accept,
   output logic [NUM_EP-1:0] ep_toggle
);
   generate
      if (NUM_EP < 1 || NUM_EP > EP_MAX) begin : g_bad_num_ep
         $fatal(1, "usb_ep_handshake: NUM_EP must be 1..16");
      end
   endgenerate

   logic     sel_in_range, sel_ctrl, sel_halt, sel_ready, sel_tog;
   verdict_t verdict;

   usbhs_ep_select #(.NUM_EP(NUM_EP)) u_sel (
      .ep       (tok_ep),
      .ctrl_vec (ep_is_ctrl),
      .halt_vec (ep_halt),
      .ready_vec(ep_ready),
      .tog_vec  (ep_toggle),
      .in_range (sel_in_range),
      .is_ctrl  (sel_ctrl),
      .halted   (sel_halt),
      .ready    (sel_ready),
      .tog      (sel_tog)
   );

   usbhs_decide u_dec (
      .is_setup(tok_is_setup),
      .data_ok (data_ok),
      .in_range(sel_in_range),
      .is_ctrl (sel_ctrl),
      .halted  (sel_halt),
      .ready   (sel_ready),
      .pid_odd (data_pid_odd),
      .tog     (sel_tog),
      .verdict (verdict)
   );

   usbhs_toggle_bank #(.NUM_EP(NUM_EP)) u_tog (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tok_valid),
      .ep     (tok_ep),
      .set    (verdict.tog_set),
      .flip   (verdict.tog_flip),
      .tog_vec(ep_toggle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_code     <= HS_NONE;
         data_accept <= 1'b0;
      end else begin
         hs_code     <= tok_valid ? verdict.code : HS_NONE;
         data_accept <= tok_valid && verdict.accept;
      end
   end
endmodule

// File: rtl/usbhs_checker.sv
module usbhs_checker #(
   parameter int NUM_EP = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tok_valid,
   input logic              tok_is_setup,
   input logic [3:0]        tok_ep,
   input logic              data_ok,
   input logic [1:0]        hs_code,
   input logic              data_accept,
   input logic [NUM_EP-1:0] ep_toggle
);
   assert_pulse_after_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_code != 2'b00) |-> $past(tok_valid));

   assert_accept_only_with_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      data_accept |-> (hs_code == 2'b01));

   assert_bad_crc_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && !data_ok) |=> (hs_code == 2'b00 && !data_accept && $stable(ep_toggle)));

   assert_setup_ep0_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tok_valid && tok_is_setup && data_ok && tok_ep == 4'd0)
      |=> (hs_code == 2'b01 && data_accept && ep_toggle[0]));

   assert_idle_toggle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !tok_valid |=> $stable(ep_toggle));

   assert_single_toggle_change_R13: assert property (@(posedge clk) disable iff (!rst_n)
      tok_valid |=> ($countones(ep_toggle ^ $past(ep_toggle)) <= 1));
endmodule

bind usb_ep_handshake usbhs_checker #(.NUM_EP(NUM_EP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tok_valid   (tok_valid),
   .tok_is_setup(tok_is_setup),
   .tok_ep      (tok_ep),
   .data_ok     (data_ok),
   .hs_code     (hs_code),
   .data_accept (data_accept),
   .ep_toggle   (ep_toggle)
);

// File: tb/usb_ep_handshake_test.sv
module usb_ep_handshake_test;
   localparam int NEP = 8;

   typedef struct {
      int         due;
      logic [1:0] code;
      logic       acc;
      logic [NEP-1:0] tog;
      string      tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           tok_valid = 1'b0;
   logic           tok_is_setup = 1'b0;
   logic [3:0]     tok_ep = 4'd0;
   logic           data_pid_odd = 1'b0;
   logic           data_ok = 1'b0;
   logic [NEP-1:0] ep_is_ctrl = 8'b0000_0010;
   logic [NEP-1:0] ep_halt = '0;
   logic [NEP-1:0] ep_ready = '1;
   logic [1:0]     hs_code;
   logic           data_accept;
   logic [NEP-1:0] ep_toggle;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [NEP-1:0] m_tog = '0;
   exp_t q[$];
   logic done = 1'b0;

   usb_ep_handshake #(.NUM_EP(NEP)) uut (
      .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_is_setup(tok_is_setup),
      .tok_ep(tok_ep), .data_pid_odd(data_pid_odd), .data_ok(data_ok),
      .ep_is_ctrl(ep_is_ctrl), .ep_halt(ep_halt), .ep_ready(ep_ready),
      .hs_code(hs_code), .data_accept(data_accept), .ep_toggle(ep_toggle)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic send(input logic setup, input int ep, input logic odd,
                       input logic ok, input string tag);
      exp_t e;
      logic ctrl;
      e.code = 2'b00; e.acc = 1'b0;
      if (ep < NEP && ok) begin
         ctrl = (ep == 0) || ep_is_ctrl[ep];
         if (setup) begin
            if (ctrl) begin e.code = 2'b01; e.acc = 1'b1; m_tog[ep] = 1'b1; end
         end else if (ep_halt[ep]) e.code = 2'b11;
         else if (!ep_ready[ep]) e.code = 2'b10;
         else begin
            e.code = 2'b01;
            if (odd == m_tog[ep]) begin e.acc = 1'b1; m_tog[ep] = ~m_tog[ep]; end
         end
      end
      e.tog = m_tog; e.due = cyc + 1; e.tag = tag;
      q.push_back(e);
      tok_valid = 1'b1; tok_is_setup = setup; tok_ep = 4'(ep);
      data_pid_odd = odd; data_ok = ok;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      tok_valid = 1'b0;
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (hs_code !== e.code || data_accept !== e.acc || ep_toggle !== e.tog) begin
               errors++;
               $display("FAIL %s: code=%b acc=%b tog=%b expected code=%b acc=%b tog=%b",
                        e.tag, hs_code, data_accept, ep_toggle, e.code, e.acc, e.tog);
            end
         end else begin
            checks++;
            if (hs_code !== 2'b00 || data_accept !== 1'b0) begin
               errors++;
               $display("FAIL R2 idle: code=%b acc=%b expected code=00 acc=0",
                        hs_code, data_accept);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (hs_code !== 2'b00 || data_accept !== 1'b0 || ep_toggle !== '0) begin
         errors++;
         $display("FAIL R1: code=%b acc=%b tog=%b expected 00 0 0", hs_code, data_accept, ep_toggle);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (hs_code !== 2'b00 || ep_toggle !== '0) begin
         errors++;
         $display("FAIL R1 after release: code=%b tog=%b expected 00 0", hs_code, ep_toggle);
      end
      send(1'b0, 2, 1'b0, 1'b1, "R10 OUT ep2 DATA0 match");
      send(1'b0, 2, 1'b0, 1'b1, "R11 OUT ep2 DATA0 mismatch");
      send(1'b0, 2, 1'b1, 1'b1, "R10 OUT ep2 DATA1 match, R2 back-to-back");
      idle(2);
      ep_halt[3] = 1'b1;
      send(1'b0, 3, 1'b0, 1'b1, "R8 OUT halted ep3");
      idle(1);
      ep_ready[4] = 1'b0;
      send(1'b0, 4, 1'b0, 1'b1, "R9 OUT not ready ep4");
      idle(1);
      ep_ready[3] = 1'b0;
      send(1'b0, 3, 1'b0, 1'b1, "R8 OUT halted and not ready ep3");
      idle(1);
      ep_halt[0] = 1'b1; ep_ready[0] = 1'b0;
      send(1'b1, 0, 1'b0, 1'b1, "R4 R7 R5 SETUP ep0 halted not ready");
      idle(1);
      send(1'b1, 1, 1'b0, 1'b1, "R5 R13 SETUP ep1");
      send(1'b1, 1, 1'b0, 1'b1, "R5 SETUP ep1 again stays 1");
      send(1'b1, 2, 1'b0, 1'b1, "R6 SETUP non-control ep2");
      send(1'b0, 2, 1'b0, 1'b0, "R3 OUT ep2 bad CRC");
      send(1'b1, 0, 1'b0, 1'b0, "R3 SETUP ep0 bad CRC");
      send(1'b0, 9, 1'b0, 1'b1, "R12 OUT ep9 out of range");
      send(1'b1, 9, 1'b0, 1'b1, "R12 SETUP ep9 out of range");
      idle(1);
      ep_halt[0] = 1'b0; ep_ready[0] = 1'b1;
      send(1'b0, 0, 1'b1, 1'b1, "R10 OUT ep0 DATA1 after SETUP");
      send(1'b0, 5, 1'b1, 1'b1, "R11 R13 OUT ep5 DATA1 mismatch");
      send(1'b0, 5, 1'b0, 1'b1, "R10 R13 OUT ep5 DATA0 match");
      idle(4);
      done = 1'b1;
      if (q.size() != 0) begin
         errors++; checks++;
         $display("FAIL R2: %0d results missing, expected 0", q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL R2: watchdog expired, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule